// File: doc/BRIEF.md
# Integer ALU with Exception Cause Reporting

This block is the combinational integer ALU of a 32-bit in-order core. One operation code, two operands `s` and `t`, a 5-bit position field and a 5-bit size field go in. A 32-bit result, a 3-bit exception cause code and an illegal-operation flag come out in the same cycle. The ALU never stops or stalls on an exception. It reports a cause code, and the pipeline stage that owns it decides what to do with that code.

Signed add and subtract are checked for two's-complement overflow. The wrapped result is produced whether or not the check fires. Six compare-and-trap operations raise the trap cause when their condition holds, and they always return zero. A shuffle operation takes its variant from the position field: it can swap bytes inside each halfword, sign-extend a byte, or sign-extend a halfword. Bit-field extract and load-upper-immediate complete the set. An unknown operation code, or a shuffle variant that is not supported, raises the illegal flag.

Top module: `alu_xcpt`

## Requirements
- R1: The operation codes are ADD=0, ADDU=1, SUB=2, SUBU=3, TGE=4, TGEU=5, TLT=6, TLTU=7, TEQ=8, TNE=9, LUI=10, SHUF=11 and EXT=12. ADDU returns s+t and SUBU returns s−t, both modulo 2^32, and both always report cause NONE.
- R2: ADD reports cause OVERFLOW when bit 31 of s equals bit 31 of t and bit 31 of the sum is different from bit 31 of s. Otherwise ADD reports NONE.
- R3: SUB reports cause OVERFLOW when bit 31 of s is different from bit 31 of t and bit 31 of s−t is different from bit 31 of s. Otherwise SUB reports NONE.
- R4: When ADD or SUB overflows, the result is still the wrapped 32-bit sum or difference. For example, 0x8FFFFFFF+0x90000000 gives 0x1FFFFFFF and 0x80000003−4 gives 0x7FFFFFFF.
- R5: Each trap operation reports cause TRAP exactly when its condition holds, and NONE otherwise. The conditions are: TGE signed s≥t, TGEU unsigned s≥t, TLT signed s<t, TLTU unsigned s<t, TEQ s==t, TNE s!=t. Every trap operation returns 0.
- R6: SHUF selects its variant from the position field sa. sa=0x02 swaps the two bytes inside each 16-bit half of t. sa=0x10 sign-extends bits 7:0 of t. sa=0x18 sign-extends bits 15:0 of t.
- R7: SHUF with any other sa value raises illegal, returns 0 and reports cause NONE.
- R8: EXT returns s shifted right by sa, masked to its low sz bits. sz=0 gives 0.
- R9: LUI returns t shifted left by 16.
- R10: Operation codes 13 to 15 raise illegal, return 0 and report cause NONE. Illegal is low for every operation code 0 to 12 except the unsupported SHUF case in R7.
- R11: The cause code is 3 bits wide: NONE=0, TRAP=4, OVERFLOW=5 (codes 1 to 3 are held for other exception sources). Only ADD, SUB and the trap operations can report a code other than NONE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation code |
| s_i | input | 32 | First operand |
| t_i | input | 32 | Second operand or immediate |
| sa_i | input | 5 | Shift/position field; shuffle variant select |
| sz_i | input | 5 | Field size for extract |
| res_o | output | 32 | Result |
| cause_o | output | 3 | Exception cause code |
| illegal_o | output | 1 | Unknown operation or unsupported shuffle variant |

## Verification
The bench targets the overflow boundaries: 0x7FFFFFFF+1, 0 minus 0x80000000, and 0x7FFFFFFF minus −1. A design that used the add rule for subtract, or took the wrong sign bit, would miss these cases or flag operands that do not overflow. The trap conditions are swept across a grid of extreme operand values where the signed and unsigned orderings disagree. A signed/unsigned swap, or an off-by-one between ≥ and >, shows up there as a wrong TRAP. The shuffle tests check byte placement, sign extension from bit 7 and from bit 15, and an unsupported variant. An extract with size zero and with full size catches a mask built with the wrong width.

// File: rtl/alu_xcpt_pkg.sv
package alu_xcpt_pkg;
  localparam int XLEN = 32;

  localparam logic [3:0] OP_ADD  = 4'd0;
  localparam logic [3:0] OP_ADDU = 4'd1;
  localparam logic [3:0] OP_SUB  = 4'd2;
  localparam logic [3:0] OP_SUBU = 4'd3;
  localparam logic [3:0] OP_TGE  = 4'd4;
  localparam logic [3:0] OP_TGEU = 4'd5;
  localparam logic [3:0] OP_TLT  = 4'd6;
  localparam logic [3:0] OP_TLTU = 4'd7;
  localparam logic [3:0] OP_TEQ  = 4'd8;
  localparam logic [3:0] OP_TNE  = 4'd9;
  localparam logic [3:0] OP_LUI  = 4'd10;
  localparam logic [3:0] OP_SHUF = 4'd11;
  localparam logic [3:0] OP_EXT  = 4'd12;

  localparam logic [2:0] CAUSE_NONE  = 3'd0;
  localparam logic [2:0] CAUSE_TRAP  = 3'd4;
  localparam logic [2:0] CAUSE_OVF   = 3'd5;

  localparam logic [4:0] SHUF_HSWAP = 5'h02;
  localparam logic [4:0] SHUF_SEXTB = 5'h10;
  localparam logic [4:0] SHUF_SEXTH = 5'h18;

  // condition selectors for the trap comparator
  typedef enum logic [2:0] {
    TC_SGE, TC_UGE, TC_SLT, TC_ULT, TC_EQ, TC_NE
  } trap_cond_e;

  function automatic logic add_overflow(input logic a_msb, input logic b_msb,
                                        input logic r_msb);
    return (a_msb == b_msb) && (r_msb != a_msb);
  endfunction

  function automatic logic sub_overflow(input logic a_msb, input logic b_msb,
                                        input logic r_msb);
    return (a_msb != b_msb) && (r_msb != a_msb);
  endfunction
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         ovf_o
);
  import alu_xcpt_pkg::*;

  always_comb begin
    sum_o = sub_i ? (a_i - b_i) : (a_i + b_i);
    ovf_o = sub_i ? sub_overflow(a_i[W-1], b_i[W-1], sum_o[W-1])
                  : add_overflow(a_i[W-1], b_i[W-1], sum_o[W-1]);
  end
endmodule

// File: rtl/alu_trapcmp.sv
module alu_trapcmp #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  alu_xcpt_pkg::trap_cond_e cond_i,
  output logic         hit_o
);
  import alu_xcpt_pkg::*;

  logic eq, ult, slt;

  always_comb begin
    eq  = (a_i == b_i);
    ult = (a_i < b_i);
    slt = ($signed(a_i) < $signed(b_i));
    unique case (cond_i)
      TC_SGE:  hit_o = !slt;
      TC_UGE:  hit_o = !ult;
      TC_SLT:  hit_o = slt;
      TC_ULT:  hit_o = ult;
      TC_EQ:   hit_o = eq;
      TC_NE:   hit_o = !eq;
      default: hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/alu_shuffle.sv
module alu_shuffle #(
  parameter int W = 32
) (
  input  logic [W-1:0] t_i,
  input  logic [4:0]   var_i,
  output logic [W-1:0] res_o,
  output logic         bad_o
);
  import alu_xcpt_pkg::*;

  localparam int NHALF = W / 16;

  logic [W-1:0] hswap;

  for (genvar h = 0; h < NHALF; h++) begin : g_half
    assign hswap[16*h +: 8]     = t_i[16*h + 8 +: 8];
    assign hswap[16*h + 8 +: 8] = t_i[16*h +: 8];
  end

  always_comb begin
    bad_o = 1'b0;
    unique case (var_i)
      SHUF_HSWAP: res_o = hswap;
      SHUF_SEXTB: res_o = {{(W-8){t_i[7]}}, t_i[7:0]};
      SHUF_SEXTH: res_o = {{(W-16){t_i[15]}}, t_i[15:0]};
      default: begin
        res_o = '0;
        bad_o = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/alu_bitfield.sv
module alu_bitfield #(
  parameter int W = 32
) (
  input  logic [W-1:0] s_i,
  input  logic [W-1:0] t_i,
  input  logic [4:0]   pos_i,
  input  logic [4:0]   size_i,
  output logic [W-1:0] ext_o,
  output logic [W-1:0] lui_o
);
  logic [W-1:0] mask;

  always_comb begin
    mask  = (W'(1) << size_i) - W'(1);
    ext_o = (s_i >> pos_i) & mask;
    lui_o = t_i << 16;
  end
endmodule

// File: rtl/alu_xcpt.sv
module alu_xcpt #(
  parameter int XLEN = alu_xcpt_pkg::XLEN
) (
  input  logic [3:0]      op_i,
  input  logic [XLEN-1:0] s_i,
  input  logic [XLEN-1:0] t_i,
  input  logic [4:0]      sa_i,
  input  logic [4:0]      sz_i,
  output logic [XLEN-1:0] res_o,
  output logic [2:0]      cause_o,
  output logic            illegal_o
);
  import alu_xcpt_pkg::*;

  // named internal events, observed by the checker
  logic            is_sub;
  logic [XLEN-1:0] arith_sum;
  logic            arith_ovf;
  trap_cond_e      tcond;
  logic            trap_hit;
  logic [XLEN-1:0] shuf_res;
  logic            shuf_bad;
  logic [XLEN-1:0] ext_res;
  logic [XLEN-1:0] lui_res;

  assign is_sub = (op_i == OP_SUB) || (op_i == OP_SUBU);

  always_comb begin
    unique case (op_i)
      OP_TGE:  tcond = TC_SGE;
      OP_TGEU: tcond = TC_UGE;
      OP_TLT:  tcond = TC_SLT;
      OP_TLTU: tcond = TC_ULT;
      OP_TEQ:  tcond = TC_EQ;
      default: tcond = TC_NE;
    endcase
  end

  alu_addsub #(.W(XLEN)) addsub_i (
    .a_i(s_i), .b_i(t_i), .sub_i(is_sub), .sum_o(arith_sum), .ovf_o(arith_ovf)
  );

  alu_trapcmp #(.W(XLEN)) trapcmp_i (
    .a_i(s_i), .b_i(t_i), .cond_i(tcond), .hit_o(trap_hit)
  );

  alu_shuffle #(.W(XLEN)) shuffle_i (
    .t_i(t_i), .var_i(sa_i), .res_o(shuf_res), .bad_o(shuf_bad)
  );

  alu_bitfield #(.W(XLEN)) bitfield_i (
    .s_i(s_i), .t_i(t_i), .pos_i(sa_i), .size_i(sz_i),
    .ext_o(ext_res), .lui_o(lui_res)
  );

  always_comb begin
    res_o     = '0;
    cause_o   = CAUSE_NONE;
    illegal_o = 1'b0;
    unique case (op_i)
      OP_ADD, OP_SUB: begin
        res_o   = arith_sum;
        cause_o = arith_ovf ? CAUSE_OVF : CAUSE_NONE;
      end
      OP_ADDU, OP_SUBU: res_o = arith_sum;
      OP_TGE, OP_TGEU, OP_TLT, OP_TLTU, OP_TEQ, OP_TNE:
        cause_o = trap_hit ? CAUSE_TRAP : CAUSE_NONE;
      OP_LUI:  res_o = lui_res;
      OP_SHUF: begin
        res_o     = shuf_res;
        illegal_o = shuf_bad;
      end
      OP_EXT:  res_o = ext_res;
      default: illegal_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/alu_xcpt_chk.sv
module alu_xcpt_chk #(
  parameter int XLEN = 32
) (
  input logic [3:0]      op_i,
  input logic [XLEN-1:0] s_i,
  input logic [XLEN-1:0] t_i,
  input logic [XLEN-1:0] res_o,
  input logic [2:0]      cause_o,
  input logic            illegal_o,
  input logic            arith_ovf,
  input logic            trap_hit,
  input logic            shuf_bad
);
  import alu_xcpt_pkg::*;

  logic known;
  assign known = !$isunknown({op_i, s_i, t_i, res_o, cause_o, illegal_o});

  always_comb begin
    if (known) begin
      // R11
      cause_legal_chk: assert (cause_o == CAUSE_NONE || cause_o == CAUSE_TRAP ||
                               cause_o == CAUSE_OVF);
      // R10
      illegal_quiet_chk: assert (!illegal_o || (res_o == '0 && cause_o == CAUSE_NONE));
      // R5
      trap_zero_chk: assert (cause_o != CAUSE_TRAP || res_o == '0);
      // R4
      ovf_wrap_chk: assert (cause_o != CAUSE_OVF ||
                            res_o == ((op_i == OP_SUB) ? s_i - t_i : s_i + t_i));
      // R2
      ovf_source_chk: assert (cause_o != CAUSE_OVF ||
                              ((op_i == OP_ADD || op_i == OP_SUB) && arith_ovf));
      // R7
      shuf_bad_chk: assert (op_i != OP_SHUF || (illegal_o == shuf_bad));
      // R1
      unsigned_quiet_chk: assert (!(op_i == OP_ADDU || op_i == OP_SUBU) ||
                                  (cause_o == CAUSE_NONE && !illegal_o));
      // R5
      trap_source_chk: assert (cause_o != CAUSE_TRAP || trap_hit);
    end
  end
endmodule

bind alu_xcpt alu_xcpt_chk #(.XLEN(XLEN)) chk_i (
  .op_i(op_i), .s_i(s_i), .t_i(t_i), .res_o(res_o), .cause_o(cause_o),
  .illegal_o(illegal_o), .arith_ovf(arith_ovf), .trap_hit(trap_hit),
  .shuf_bad(shuf_bad)
);

// File: tb/alu_xcpt_tb_top.sv
module alu_xcpt_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;
  logic rst_n;

  logic [3:0]  op;
  logic [31:0] s, t, res;
  logic [4:0]  sa, sz;
  logic [2:0]  cause;
  logic        ill;

  int total = 0;
  int bad = 0;

  alu_xcpt dut_i (
    .op_i(op), .s_i(s), .t_i(t), .sa_i(sa), .sz_i(sz),
    .res_o(res), .cause_o(cause), .illegal_o(ill)
  );

  // {op, s, t, sa, sz, res, cause, ill}
  localparam int NV = 20;
  localparam logic [113:0] VEC [NV] = '{
    {4'd0, 32'h8FFFFFFF, 32'h90000000, 5'd0, 5'd0, 32'h1FFFFFFF, 3'd5, 1'b0},
    {4'd1, 32'h8FFFFFFF, 32'h90000000, 5'd0, 5'd0, 32'h1FFFFFFF, 3'd0, 1'b0},
    {4'd2, 32'h80000003, 32'h00000004, 5'd0, 5'd0, 32'h7FFFFFFF, 3'd5, 1'b0},
    {4'd2, 32'h00000005, 32'h00000003, 5'd0, 5'd0, 32'h00000002, 3'd0, 1'b0},
    {4'd3, 32'h80000003, 32'h00000004, 5'd0, 5'd0, 32'h7FFFFFFF, 3'd0, 1'b0},
    {4'd0, 32'h7FFFFFFF, 32'h00000001, 5'd0, 5'd0, 32'h80000000, 3'd5, 1'b0},
    {4'd0, 32'h7FFFFFFF, 32'hFFFFFFFF, 5'd0, 5'd0, 32'h7FFFFFFE, 3'd0, 1'b0},
    {4'd2, 32'h00000000, 32'h80000000, 5'd0, 5'd0, 32'h80000000, 3'd5, 1'b0},
    {4'd2, 32'h7FFFFFFF, 32'hFFFFFFFF, 5'd0, 5'd0, 32'h80000000, 3'd5, 1'b0},
    {4'd8, 32'h12345678, 32'h12345678, 5'd0, 5'd0, 32'h00000000, 3'd4, 1'b0},
    {4'd8, 32'h12345679, 32'h12345678, 5'd0, 5'd0, 32'h00000000, 3'd0, 1'b0},
    {4'd9, 32'h12345678, 32'h12345679, 5'd0, 5'd0, 32'h00000000, 3'd4, 1'b0},
    {4'd10, 32'h00000000, 32'h0000ABCD, 5'd0, 5'd0, 32'hABCD0000, 3'd0, 1'b0},
    {4'd11, 32'h00000000, 32'h11223344, 5'h02, 5'd0, 32'h22114433, 3'd0, 1'b0},
    {4'd11, 32'h00000000, 32'h00000080, 5'h10, 5'd0, 32'hFFFFFF80, 3'd0, 1'b0},
    {4'd11, 32'h00000000, 32'h12348001, 5'h18, 5'd0, 32'hFFFF8001, 3'd0, 1'b0},
    {4'd11, 32'hFFFFFFFF, 32'h11223344, 5'h03, 5'd0, 32'h00000000, 3'd0, 1'b1},
    {4'd12, 32'hABCD1234, 32'h00000000, 5'd4, 5'd8, 32'h00000023, 3'd0, 1'b0},
    {4'd12, 32'hFFFFFFFF, 32'h00000000, 5'd0, 5'd0, 32'h00000000, 3'd0, 1'b0},
    {4'd12, 32'hFFFFFFFF, 32'h00000000, 5'd0, 5'd31, 32'h7FFFFFFF, 3'd0, 1'b0}
  };
  localparam string VTAG [NV] = '{
    "R2", "R1", "R3", "R3", "R1", "R2", "R2", "R3", "R4", "R5",
    "R5", "R5", "R9", "R6", "R6", "R6", "R7", "R8", "R8", "R8"
  };

  task automatic apply(input logic [3:0] o, input logic [31:0] a, input logic [31:0] b,
                       input logic [4:0] p, input logic [4:0] z);
    @(negedge clk);
    op = o; s = a; t = b; sa = p; sz = z;
    #1;
  endtask

  task automatic check(input string tag, input logic [31:0] er, input logic [2:0] ec,
                       input logic ei);
    total++;
    if (res !== er || cause !== ec || ill !== ei) begin
      bad++;
      $display("FAIL %s op=%0d s=%h t=%h: got res=%h cause=%0d ill=%b, expected res=%h cause=%0d ill=%b",
               tag, op, s, t, res, cause, ill, er, ec, ei);
    end
  endtask

  function automatic logic trap_model(input logic [3:0] o, input logic [31:0] a,
                                      input logic [31:0] b);
    logic signed [32:0] sa33, sb33;
    sa33 = {a[31], a};
    sb33 = {b[31], b};
    case (o)
      4'd4: return sa33 >= sb33;
      4'd5: return {1'b0, a} >= {1'b0, b};
      4'd6: return sa33 < sb33;
      4'd7: return {1'b0, a} < {1'b0, b};
      4'd8: return a == b;
      default: return a != b;
    endcase
  endfunction

  localparam logic [31:0] EDGE [4] = '{32'h00000000, 32'h7FFFFFFF, 32'h80000000, 32'hFFFFFFFF};

  initial begin
    #1_000_000;
    total++;
    bad++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    op = '0; s = '0; t = '0; sa = '0; sz = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // quiet state with all-zero inputs (R1)
    apply(4'd0, 32'h0, 32'h0, 5'd0, 5'd0);
    check("R1 idle", 32'h0, 3'd0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][113:110], VEC[i][109:78], VEC[i][77:46], VEC[i][45:41], VEC[i][40:36]);
      check(VTAG[i], VEC[i][35:4], VEC[i][3:1], VEC[i][0]);
    end

    // R5: trap conditions across signed/unsigned extremes
    for (int o = 4; o <= 9; o++)
      for (int i = 0; i < 4; i++)
        for (int j = 0; j < 4; j++) begin
          apply(4'(o), EDGE[i], EDGE[j], 5'd0, 5'd0);
          check("R5 sweep", 32'h0, trap_model(4'(o), EDGE[i], EDGE[j]) ? 3'd4 : 3'd0, 1'b0);
        end

    // R10: unknown operation codes
    for (int o = 13; o <= 15; o++) begin
      apply(4'(o), 32'hDEADBEEF, 32'h12345678, 5'h02, 5'd7);
      check("R10 unknown op", 32'h0, 3'd0, 1'b0 | 1'b1);
    end

    // R11: non-exception ops never raise a cause, even on overflowing operands
    apply(4'd3, 32'h80000000, 32'h00000001, 5'd0, 5'd0);
    check("R11 subu", 32'h7FFFFFFF, 3'd0, 1'b0);
    apply(4'd10, 32'h7FFFFFFF, 32'hFFFFFFFF, 5'd0, 5'd0);
    check("R11 lui", 32'hFFFF0000, 3'd0, 1'b0);

    // R7: another unsupported shuffle variant, followed by a supported one
    apply(4'd11, 32'h0, 32'h000000FF, 5'h00, 5'd0);
    check("R7 variant 0", 32'h0, 3'd0, 1'b1);
    apply(4'd11, 32'h0, 32'h00007F00, 5'h18, 5'd0);
    check("R6 positive half", 32'h00007F00, 3'd0, 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule